// File: doc/BRIEF.md
# Synchronous Serial Frame Master

This block is the master end of a word-per-frame serial link. Framing uses a short sync pulse rather than a select line. The host writes words into an 8-entry transmit FIFO and takes received words from an 8-entry receive FIFO. Both FIFOs use a valid/ready handshake and report empty and full.

On the serial side the block drives these signals:
- a bit clock, made by dividing the system clock with a programmable prescaler;
- a frame-sync output;
- a transmit data line with an output enable, so a pad can tristate it.

It samples a receive data line. The frame length is selectable from 4 to 16 bits. Each frame starts with a sync pulse one bit clock long. The word follows MSB first, and the slave answers on the receive line in the same bit periods.

When more words are waiting, frames run back to back. The next sync pulse overlaps the current frame's LSB period, and the next MSB follows with no idle gap. When the transmit FIFO runs dry, the port returns to idle after the LSB period. A received word that finds the receive FIFO full is dropped, and a sticky overrun flag is raised. The flag stays set until the host clears it.

Top module: `ssf_master`

## Requirements
- R1: While no frame is in progress, `sclk_o` and `fs_o` are low and `sd_oe_o` is low (transmit line released); this is also the state after reset.
- R2: When the transmit FIFO is non-empty and the port is idle, a word is removed from the FIFO and `fs_o` goes high together with a rising edge of `sclk_o`; it stays high for exactly one bit-clock period.
- R3: The MSB of the frame appears on `sd_o` at the rising `sclk_o` edge that ends the sync period, and each further bit, MSB first, changes only on rising edges. A frame of S bits sends bits S-1..0 of the FIFO entry.
- R4: The frame length is taken from `cfg_size_i` (5 bits). Values 4 to 16 give that many bits, values below 4 give 4 bits, and values above 16 give 16 bits.
- R5: `sd_i` is sampled at each falling `sclk_o` edge of the data bits. At the first rising bit-clock event after the LSB is sampled, the word enters the receive FIFO, right-justified and zero-extended to 16 bits, in frame order.
- R6: If the transmit FIFO is non-empty at the rising edge that starts a frame's LSB period, `fs_o` is high during that LSB period, and the next MSB follows on the next rising edge with no idle gap.
- R7: Each half of the bit clock lasts `cfg_div_i`+1 system clocks, so consecutive rising edges within a run of frames are 2*(`cfg_div_i`+1) system clocks apart.
- R8: `cfg_size_i` and `cfg_div_i` are sampled only when a frame starts from idle. Changes during a run of frames take no effect until the port has been idle.
- R9: If the transmit FIFO is empty at the start of the LSB period, the port returns to idle when that period ends, without another rising edge.
- R10: A received word that finds the receive FIFO full is discarded and sets `ovr_o`. `ovr_o` stays set until a cycle with `ovr_clr_i` high, and it reads low on the following cycle.
- R11: Each FIFO holds 8 words of 16 bits in order. `tx_ready_o` equals not `tx_full_o`, `rx_valid_o` equals not `rx_empty_o`, and `rx_full_o` is high when 8 words are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size_i | input | 5 | Frame length in bits, clamped to 4..16 |
| cfg_div_i | input | 8 | Prescaler value N; bit period is 2*(N+1) clocks |
| tx_valid_i | input | 1 | Host offers a transmit word |
| tx_ready_o | output | 1 | Transmit FIFO can accept a word |
| tx_data_i | input | 16 | Transmit word, low bits used |
| rx_valid_o | output | 1 | Receive FIFO holds a word |
| rx_ready_i | input | 1 | Host takes the head receive word |
| rx_data_o | output | 16 | Head receive word |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| tx_full_o | output | 1 | Transmit FIFO full |
| rx_empty_o | output | 1 | Receive FIFO empty |
| rx_full_o | output | 1 | Receive FIFO full |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| ovr_o | output | 1 | Sticky receive overrun flag |
| sclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame-sync pulse |
| sd_o | output | 1 | Transmit data |
| sd_oe_o | output | 1 | Drive enable for transmit data |
| sd_i | input | 1 | Receive data |

## Verification
The assertions check the following on every cycle:
- the serial outputs are quiet whenever the data line is released;
- the sync pulse and data bits change only with a rising bit clock;
- the sync pulse never spans two rising edges;
- the prescaler count stays within its limit;
- no FIFO is written when full;
- the overrun flag sets and holds.

Only the bench's scenarios can show the rest:
- word content, MSB-first order and size clamping;
- exact bit periods across back-to-back frames;
- return to idle when the FIFO drains;
- settings ignored mid-run;
- which received words survive an overrun.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_DATA} ssf_state_t;
endpackage

// File: rtl/ssf_fifo.sv
module ssf_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             do_wr, do_rd;

  assign do_wr     = wr_en_i && !full_o;
  assign do_rd     = rd_en_i && !empty_o;
  assign empty_o   = (count == '0);
  assign full_o    = (count == CW'(DEPTH));
  assign rd_data_o = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_no_write_full_R11: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |-> !full_o);
endmodule

// File: rtl/ssf_prescale.sv
module ssf_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;

  assign tick_o = run_i && (cnt == div_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt <= '0;
    else if (cnt == div_i) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
    run_i |-> cnt <= div_i);
endmodule

// File: rtl/ssf_engine.sv
module ssf_engine
  import ssf_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int DIV_W    = 8,
  parameter int SIZE_W   = 5,
  parameter int MIN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] cfg_size_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic              tick_i,
  output logic              run_o,
  output logic [DIV_W-1:0]  div_o,
  input  logic              tx_avail_i,
  input  logic [DATA_W-1:0] tx_word_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_word_o,
  input  logic              sd_i,
  output logic              sclk_o,
  output logic              fs_o,
  output logic              sd_o,
  output logic              sd_oe_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  ssf_state_t        state;
  logic [DATA_W-1:0] shreg, rxsh;
  logic [CNT_W-1:0]  bitcnt, size_q, size_c;
  logic              nxt, rx_done;

  always_comb begin
    if (cfg_size_i < SIZE_W'(MIN_BITS))    size_c = CNT_W'(MIN_BITS);
    else if (cfg_size_i > SIZE_W'(DATA_W)) size_c = CNT_W'(DATA_W);
    else                                   size_c = CNT_W'(cfg_size_i);
  end

  assign run_o = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sclk_o    <= 1'b0;
      fs_o      <= 1'b0;
      sd_o      <= 1'b0;
      sd_oe_o   <= 1'b0;
      tx_pop_o  <= 1'b0;
      rx_push_o <= 1'b0;
      rx_word_o <= '0;
      shreg     <= '0;
      rxsh      <= '0;
      bitcnt    <= '0;
      size_q    <= CNT_W'(MIN_BITS);
      div_o     <= '0;
      nxt       <= 1'b0;
      rx_done   <= 1'b0;
    end else begin
      tx_pop_o  <= 1'b0;
      rx_push_o <= 1'b0;
      if (state == ST_IDLE) begin
        if (tx_avail_i) begin
          state    <= ST_SYNC;
          tx_pop_o <= 1'b1;
          shreg    <= tx_word_i;
          size_q   <= size_c;
          div_o    <= cfg_div_i;
          sclk_o   <= 1'b1;
          fs_o     <= 1'b1;
          sd_oe_o  <= 1'b1;
          sd_o     <= 1'b0;
          rxsh     <= '0;
        end
      end else if (tick_i) begin
        if (sclk_o) begin
          // falling edge: sample receive line during data bits
          sclk_o <= 1'b0;
          if (state == ST_DATA) begin
            rxsh <= {rxsh[DATA_W-2:0], sd_i};
            if (bitcnt == '0) rx_done <= 1'b1;
          end
        end else begin
          // rising event: hand over a completed word first
          if (rx_done) begin
            rx_done   <= 1'b0;
            rx_push_o <= 1'b1;
            rx_word_o <= rxsh;
          end
          if (state == ST_SYNC || (bitcnt == '0 && nxt)) begin
            sclk_o <= 1'b1;
            fs_o   <= 1'b0;
            nxt    <= 1'b0;
            state  <= ST_DATA;
            bitcnt <= size_q - 1'b1;
            sd_o   <= shreg[size_q - 1'b1];
            rxsh   <= '0;
          end else if (bitcnt == '0) begin
            fs_o    <= 1'b0;
            sd_oe_o <= 1'b0;
            sd_o    <= 1'b0;
            state   <= ST_IDLE;
          end else begin
            sclk_o <= 1'b1;
            bitcnt <= bitcnt - 1'b1;
            sd_o   <= shreg[bitcnt - 1'b1];
            if (bitcnt == CNT_W'(1) && tx_avail_i) begin
              // LSB period: overlap the next sync pulse
              tx_pop_o <= 1'b1;
              shreg    <= tx_word_i;
              fs_o     <= 1'b1;
              nxt      <= 1'b1;
            end else begin
              fs_o <= 1'b0;
            end
          end
        end
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !sd_oe_o |-> (!sclk_o && !fs_o));
  assert_sync_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(fs_o) |-> $rose(sclk_o));
  assert_sync_one_period_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> !(fs_o && $past(fs_o)));
  assert_data_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (sd_oe_o && $past(sd_oe_o) && !$stable(sd_o)) |-> $rose(sclk_o));
endmodule

// File: rtl/ssf_master.sv
module ssf_master #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int DIV_W  = 8,
  parameter int SIZE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] cfg_size_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tx_empty_o,
  output logic              tx_full_o,
  output logic              rx_empty_o,
  output logic              rx_full_o,
  input  logic              ovr_clr_i,
  output logic              ovr_o,
  output logic              sclk_o,
  output logic              fs_o,
  output logic              sd_o,
  output logic              sd_oe_o,
  input  logic              sd_i
);
  logic              tick, run, tx_pop, rx_push;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] tx_head, rx_word;

  assign tx_ready_o = !tx_full_o;
  assign rx_valid_o = !rx_empty_o;

  ssf_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst(rst),
    .wr_en_i(tx_valid_i && !tx_full_o), .wr_data_i(tx_data_i),
    .rd_en_i(tx_pop), .rd_data_o(tx_head),
    .empty_o(tx_empty_o), .full_o(tx_full_o));

  ssf_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst(rst),
    .wr_en_i(rx_push && !rx_full_o), .wr_data_i(rx_word),
    .rd_en_i(rx_ready_i), .rd_data_o(rx_data_o),
    .empty_o(rx_empty_o), .full_o(rx_full_o));

  ssf_prescale #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run_i(run), .div_i(div_q), .tick_o(tick));

  ssf_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W), .SIZE_W(SIZE_W)) u_eng (
    .clk(clk), .rst(rst),
    .cfg_size_i(cfg_size_i), .cfg_div_i(cfg_div_i),
    .tick_i(tick), .run_o(run), .div_o(div_q),
    .tx_avail_i(!tx_empty_o), .tx_word_i(tx_head), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_word_o(rx_word),
    .sd_i(sd_i), .sclk_o(sclk_o), .fs_o(fs_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o));

  always_ff @(posedge clk) begin
    if (rst)                        ovr_o <= 1'b0;
    else if (rx_push && rx_full_o)  ovr_o <= 1'b1;
    else if (ovr_clr_i)             ovr_o <= 1'b0;
  end

  assert_overrun_set_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full_o) |=> ovr_o);
  assert_overrun_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (ovr_o && !ovr_clr_i) |=> ovr_o);
endmodule

// File: tb/ssf_master_tb.sv
module ssf_master_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  cfg_size = 5'd8;
  logic [7:0]  cfg_div = 8'd0;
  logic        tx_valid = 1'b0, rx_ready = 1'b0, ovr_clr = 1'b0, sd_in = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_ready, rx_valid, tx_empty, tx_full, rx_empty, rx_full, ovr;
  logic        sclk, fs, sd, sd_oe;
  logic [15:0] rx_data;

  always #10 clk = ~clk;

  ssf_master u_dut (
    .clk(clk), .rst(rst), .cfg_size_i(cfg_size), .cfg_div_i(cfg_div),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data),
    .tx_empty_o(tx_empty), .tx_full_o(tx_full), .rx_empty_o(rx_empty),
    .rx_full_o(rx_full), .ovr_clr_i(ovr_clr), .ovr_o(ovr),
    .sclk_o(sclk), .fs_o(fs), .sd_o(sd), .sd_oe_o(sd_oe), .sd_i(sd_in));

  int checks = 0, fails = 0;
  bit finished = 0;
  int msize = 8, mdiv = 0;
  logic [15:0] txq[$], rxq[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int clamp(input int s);
    return (s < 4) ? 4 : (s > 16) ? 16 : s;
  endfunction

  function automatic logic [15:0] mask(input int s);
    return 16'((32'd1 << s) - 1);
  endfunction

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Slave-side monitor
  int cyc = 0, last_rise = 0, bitidx = 0;
  bit cont = 0, active = 0, sync_seen = 0, psclk = 0;
  logic [15:0] cap, rw;
  always @(negedge clk) if (!rst) begin
    cyc++;
    if (!sd_oe) begin
      cont = 0;
      if (sclk || fs) check(0, "R1 idle outputs", {sclk, fs}, 0);
    end
    if (sclk && !psclk) begin
      if (cont) check(cyc - last_rise == 2*(mdiv+1), "R7 bit period", cyc - last_rise, 2*(mdiv+1));
      last_rise = cyc;
      cont = 1;
      if (sync_seen) begin
        active = 1; bitidx = msize - 1; cap = '0;
        rw = 16'($urandom) & mask(msize);
        sd_in = rw[bitidx];
      end else if (active && bitidx > 0) begin
        bitidx--; sd_in = rw[bitidx];
      end else if (!fs) begin
        check(0, "R9 unexpected rising edge", 1, 0);
      end
      if (fs) check(!active || bitidx == 0, "R2 R6 sync placement", bitidx, 0);
      sync_seen = fs;
    end
    if (!sclk && psclk && active) begin
      if (!sd_oe) check(0, "R3 line released mid-frame", 0, 1);
      cap = (cap << 1) | 16'(sd);
      if (bitidx == 0) begin
        logic [15:0] e;
        e = (txq.size() > 0) ? txq.pop_front() : 16'hdead;
        check(cap == e, "R3 R4 transmitted word", cap, e);
        rxq.push_back(rw);
        active = 0;
      end
    end
    psclk = sclk;
  end

  task automatic push(input logic [15:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1; tx_data = d;
    txq.push_back(d & mask(msize));
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (!(tx_empty && !sd_oe && !active)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic drain;
    @(negedge clk);
    while (rx_valid) begin
      logic [15:0] e;
      e = (rxq.size() > 0) ? rxq.pop_front() : 16'hbeef;
      check(rx_data == e, "R5 received word", rx_data, e);
      rx_ready = 1;
      @(negedge clk);
      rx_ready = 0;
    end
    check(rxq.size() == 0, "R5 R11 receive count", rxq.size(), 0);
  endtask

  task automatic config_set(input int s, input int d);
    cfg_size = 5'(s); cfg_div = 8'(d);
    msize = clamp(s); mdiv = d;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    check(!sclk && !fs && !sd_oe, "R1 reset serial outputs", {sclk, fs, sd_oe}, 0);
    check(tx_empty && rx_empty && !tx_full && !rx_full && !ovr, "R11 reset flags",
          {tx_empty, rx_empty, tx_full, rx_full, ovr}, 5'b11000);

    // single frame, idle afterwards
    config_set(8, 0);
    push(16'hA5C3);
    wait_idle();
    check(!sd_oe && !sclk, "R9 returns to idle", sd_oe, 0);
    drain();

    // back-to-back burst, 16 bits
    config_set(16, 2);
    for (int i = 0; i < 5; i++) push(16'h1234 + 16'(i * 16'h1111));
    wait_idle();
    drain();

    // size clamping
    config_set(2, 1);
    for (int i = 0; i < 3; i++) push(16'hFFF0 | 16'(i + 5));
    wait_idle(); drain();
    config_set(31, 0);
    push(16'h8001); push(16'h7FFE);
    wait_idle(); drain();

    // settings changed mid-run are ignored
    config_set(8, 1);
    for (int i = 0; i < 3; i++) push(16'h00C5 + 16'(i));
    repeat (20) @(negedge clk);
    cfg_size = 5'd12; cfg_div = 8'd3;   // monitor keeps old settings: R8
    wait_idle(); drain();
    check(rxq.size() == 0 && txq.size() == 0, "R8 old settings kept", txq.size(), 0);
    config_set(12, 3);
    push(16'h0ABC);
    wait_idle(); drain();

    // random rounds
    for (int r = 0; r < 8; r++) begin
      int n;
      config_set(4 + int'($urandom_range(0, 12)), int'($urandom_range(0, 3)));
      n = int'($urandom_range(1, 6));
      for (int i = 0; i < n; i++) push(16'($urandom));
      wait_idle(); drain();
    end

    // overrun: 10 words into an 8-deep receive FIFO
    config_set(4, 0);
    for (int i = 0; i < 10; i++) push(16'(i));
    wait_idle();
    check(ovr == 1'b1, "R10 overrun set", ovr, 1);
    check(rx_full == 1'b1, "R11 receive full", rx_full, 1);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] e;
      e = rxq.pop_front();
      check(rx_data == e, "R10 kept word", rx_data, e);
      rx_ready = 1; @(negedge clk); rx_ready = 0;
    end
    check(rx_empty && rxq.size() == 2, "R10 two words dropped", rxq.size(), 2);
    rxq.delete();
    check(ovr == 1'b1, "R10 flag sticky", ovr, 1);
    ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    check(ovr == 1'b0, "R10 flag cleared", ovr, 0);

    summary();
  end
endmodule